// File: doc/BRIEF.md
# HDLC Receive Deframer

This block turns a serial HDLC bit stream into payload bytes for a controller. It hunts for the 0x7E flag, removes the zero inserted after every run of five ones, and assembles bytes least significant bit first. It also runs a CRC-16-CCITT over each frame. Bits arrive one per cycle while `bit_valid` is high, and gaps of any length are allowed.

The last two bytes before a closing flag are the frame check sequence. They are held back and never reach the controller. Payload bytes are written into a 21-byte receive queue under a provisional pointer, and become readable only once the closing flag accepts the frame. An abort, a short frame or a frame that is not byte-aligned winds the provisional pointer back, so none of that frame's bytes appear. When a frame is accepted, the block sets a sticky frame-end flag, reports whether the CRC residue was correct, and latches the residue into two byte registers. The controller reads bytes through a one-byte output register that has a ready flag.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Flags (0x7E) and the two trailing check bytes never reach `rd_data`. Payload bytes are assembled with the first received bit in bit 0 and are delivered in arrival order.
- R2: A 0 received directly after five consecutive 1s is deleted from the data.
- R3: At most 21 unread bytes are held, counting the output register. Payload bytes that arrive while 21 are held are dropped, and the earlier bytes remain in order.
- R4: `fifo_empty` is 1 exactly when no unread byte is held.
- R5: `data_ready` goes to 1 when a byte is loaded into the output register. It holds that byte until `rd_en` is asserted, and it drops to 0 after a read when no further byte is held.
- R6: `frame_end` is set when a closing flag accepts a frame. It is cleared only by `rst_n` or `sync_clr`.
- R7: `frame_good` is 1 when the CRC-16-CCITT (reflected polynomial 0x8408, start value 0xFFFF) run over the payload and the check bytes of the last accepted frame leaves the residue 0xF0B8, and 0 otherwise.
- R8: `crc_lo` and `crc_hi` hold bits 7:0 and 15:8 of the last accepted frame's residue. They change only when a frame is accepted.
- R9: Seven or more consecutive 1s abort the frame in progress. None of its bytes become readable, the status outputs keep their values, and hunting resumes until the next flag.
- R10: A frame with fewer than 4 bytes between flags, or with a bit count between flags that is not a multiple of 8, is discarded without any change to the status outputs.
- R11: Bits received before the first flag are ignored.
- R12: After reset, `fifo_empty` is 1 and `data_ready`, `frame_end`, `frame_good`, `crc_lo` and `crc_hi` are 0.
- R13: A frame whose CRC fails still delivers its payload bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_clr | input | 1 | Synchronous clear of all state, active high |
| bit_valid | input | 1 | `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit |
| rd_en | input | 1 | Consume the byte in the output register |
| rd_data | output | 8 | Output register byte |
| data_ready | output | 1 | Output register holds an unread byte |
| fifo_empty | output | 1 | No unread byte is held |
| frame_end | output | 1 | Sticky: a frame has been accepted |
| frame_good | output | 1 | CRC result of the last accepted frame |
| crc_lo | output | 8 | Residue bits 7:0 of the last accepted frame |
| crc_hi | output | 8 | Residue bits 15:8 of the last accepted frame |

## Verification
The deframer is driven with frames of random length and content, biased toward 0xFF and 0x7E bytes so that runs of five ones and stuffed zeros occur often. Random idle gaps are inserted between bits, which shows that byte assembly depends only on qualified bits. Frames with a corrupted check byte separate the CRC verdict from payload delivery. Directed aborts, three-byte frames, misaligned frames, a 25-byte frame read only after it closes, and pre-flag noise each check that a discarded or clipped frame leaves no bytes and no status change behind.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int unsigned FLAG_PREFIX = 6;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD_RESIDUE = 16'hF0B8;

    function automatic logic [15:0] crc_step(input logic [15:0] crc, input logic b);
        logic [15:0] c;
        c = crc >> 1;
        if (crc[0] ^ b) begin
            c = c ^ CRC_POLY_REFL;
        end
        return c;
    endfunction
endpackage

// File: rtl/hdlc_bit_stage.sv
module hdlc_bit_stage
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic bit_valid_i,
    input  logic bit_in_i,
    output logic dvalid_o,
    output logic dbit_o,
    output logic flag_o,
    output logic abort_o
);
    localparam int unsigned FW = $clog2(FLAG_PREFIX + 1);

    typedef struct packed {
        logic [2:0]             ones;
        logic [FLAG_PREFIX-1:0] dly;
        logic [FW-1:0]          fill;
    } st_t;

    localparam st_t ST_RST = '{default: '0};

    st_t  s_q, s_d;
    logic acc;

    always_comb begin
        s_d      = s_q;
        acc      = 1'b0;
        flag_o   = 1'b0;
        abort_o  = 1'b0;
        dvalid_o = 1'b0;
        dbit_o   = s_q.dly[FLAG_PREFIX-1];
        if (bit_valid_i) begin
            if (bit_in_i) begin
                if (s_q.ones < 3'd5) begin
                    acc       = 1'b1;
                    s_d.ones  = s_q.ones + 3'd1;
                end else if (s_q.ones == 3'd5) begin
                    s_d.ones  = 3'd6;
                end else begin
                    s_d.ones  = 3'd7;
                    s_d.fill  = '0;
                    abort_o   = (s_q.ones == 3'd6);
                end
            end else begin
                s_d.ones = 3'd0;
                if (s_q.ones == 3'd6) begin
                    flag_o   = 1'b1;
                    s_d.fill = '0;
                end else if (s_q.ones != 3'd5) begin
                    acc = 1'b1;
                end
            end
        end
        if (acc) begin
            s_d.dly = {s_q.dly[FLAG_PREFIX-2:0], bit_in_i};
            if (s_q.fill == FW'(FLAG_PREFIX)) begin
                dvalid_o = 1'b1;
            end else begin
                s_d.fill = s_q.fill + FW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= ST_RST;
        end else if (clr_i) begin
            s_q <= ST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: a stuffed zero (after exactly five ones) never leaves as data on the next bit
    a_r2_stuff_not_flag: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (bit_valid_i && !bit_in_i && s_q.ones == 3'd5) |=> (s_q.ones == 3'd0 && !flag_o));
endmodule

// File: rtl/hdlc_frame_stage.sv
module hdlc_frame_stage
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned MIN_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  logic        dvalid_i,
    input  logic        dbit_i,
    input  logic        flag_i,
    input  logic        abort_i,
    output logic        push_o,
    output logic [7:0]  push_data_o,
    output logic        commit_o,
    output logic        rollback_o,
    output logic        frame_end_o,
    output logic        frame_good_o,
    output logic [15:0] crc_o
);
    localparam int unsigned NB_W = $clog2(MIN_BYTES + 1);

    typedef struct packed {
        logic            in_frame;
        logic [7:0]      sh;
        logic [2:0]      bitcnt;
        logic [NB_W-1:0] nbytes;
        logic [7:0]      h_new;
        logic [7:0]      h_old;
        logic [1:0]      hcnt;
        logic [15:0]     crc;
        logic            fend;
        logic            good;
        logic [15:0]     crc_out;
    } st_t;

    localparam st_t ST_RST = '{crc: CRC_INIT, default: '0};

    st_t        s_q, s_d;
    logic [7:0] nsh;
    logic       has_bits;

    always_comb begin
        s_d         = s_q;
        push_o      = 1'b0;
        push_data_o = s_q.h_old;
        commit_o    = 1'b0;
        rollback_o  = 1'b0;
        nsh         = {dbit_i, s_q.sh[7:1]};
        has_bits    = (s_q.nbytes != '0) || (s_q.bitcnt != 3'd0);

        if (dvalid_i && s_q.in_frame) begin
            s_d.crc    = crc_step(s_q.crc, dbit_i);
            s_d.sh     = nsh;
            s_d.bitcnt = s_q.bitcnt + 3'd1;
            if (s_q.bitcnt == 3'd7) begin
                if (s_q.nbytes != NB_W'(MIN_BYTES)) begin
                    s_d.nbytes = s_q.nbytes + NB_W'(1);
                end
                s_d.h_new = nsh;
                s_d.h_old = s_q.h_new;
                if (s_q.hcnt == 2'd2) begin
                    push_o = 1'b1;
                end else begin
                    s_d.hcnt = s_q.hcnt + 2'd1;
                end
            end
        end

        if (flag_i) begin
            if (s_q.in_frame && has_bits) begin
                if (s_q.nbytes == NB_W'(MIN_BYTES) && s_q.bitcnt == 3'd0) begin
                    commit_o    = 1'b1;
                    s_d.fend    = 1'b1;
                    s_d.good    = (s_q.crc == CRC_GOOD_RESIDUE);
                    s_d.crc_out = s_q.crc;
                end else begin
                    rollback_o = 1'b1;
                end
            end
            s_d.in_frame = 1'b1;
            s_d.bitcnt   = 3'd0;
            s_d.nbytes   = '0;
            s_d.hcnt     = 2'd0;
            s_d.crc      = CRC_INIT;
        end

        if (abort_i && s_q.in_frame) begin
            rollback_o   = 1'b1;
            s_d.in_frame = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= ST_RST;
        end else if (clr_i) begin
            s_q <= ST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_end_o  = s_q.fend;
    assign frame_good_o = s_q.good;
    assign crc_o        = s_q.crc_out;

    // R1: a flag bit is never also a payload bit
    a_r1_flag_not_data: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        flag_i |-> !dvalid_i);
    // R6: frame end stays set until a clear
    a_r6_frame_end_sticky: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        s_q.fend |=> s_q.fend);
    // R8: residue registers move only on an accepted frame
    a_r8_crc_hold: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        !commit_o |=> $stable(s_q.crc_out));
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
    parameter int unsigned DEPTH = 21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       push_i,
    input  logic [7:0] push_data_i,
    input  logic       commit_i,
    input  logic       rollback_i,
    input  logic       rd_en_i,
    output logic [7:0] rd_data_o,
    output logic       data_ready_o,
    output logic       fifo_empty_o
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rd_ptr;
        logic [PW-1:0] cm_ptr;
        logic [PW-1:0] sp_ptr;
        logic [CW-1:0] cm_cnt;
        logic [CW-1:0] sp_cnt;
        logic          out_v;
        logic [7:0]    out_data;
    } st_t;

    localparam st_t ST_RST = '{default: '0};

    st_t         s_q, s_d;
    logic [7:0]  mem_q [DEPTH];
    logic [CW:0] used;
    logic        accept;
    logic        pop;
    logic [CW-1:0] cm_sum;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        s_d    = s_q;
        used   = {1'b0, s_q.cm_cnt} + {1'b0, s_q.sp_cnt} + {{CW{1'b0}}, s_q.out_v};
        accept = push_i && (used < (CW+1)'(DEPTH));
        pop    = (!s_q.out_v || rd_en_i) && (s_q.cm_cnt != '0);
        cm_sum = s_q.cm_cnt + (commit_i ? s_q.sp_cnt : '0);

        if (accept) begin
            s_d.sp_ptr = nxt(s_q.sp_ptr);
            s_d.sp_cnt = s_q.sp_cnt + CW'(1);
        end
        if (commit_i) begin
            s_d.cm_ptr = s_q.sp_ptr;
            s_d.sp_cnt = '0;
        end
        if (rollback_i) begin
            s_d.sp_ptr = s_q.cm_ptr;
            s_d.sp_cnt = '0;
        end
        s_d.cm_cnt = cm_sum - (pop ? CW'(1) : '0);
        if (pop) begin
            s_d.out_data = mem_q[s_q.rd_ptr];
            s_d.out_v    = 1'b1;
            s_d.rd_ptr   = nxt(s_q.rd_ptr);
        end else if (rd_en_i) begin
            s_d.out_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem_q[s_q.sp_ptr] <= push_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= ST_RST;
        end else if (clr_i) begin
            s_q <= ST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data_o    = s_q.out_data;
    assign data_ready_o = s_q.out_v;
    assign fifo_empty_o = !s_q.out_v && (s_q.cm_cnt == '0);

    // R3: held bytes never exceed the capacity
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        ({1'b0, s_q.cm_cnt} + {1'b0, s_q.sp_cnt} + {{CW{1'b0}}, s_q.out_v}) <= (CW+1)'(DEPTH));
    // R3: accept and provisional writes never coincide
    a_r3_commit_no_push: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (commit_i || rollback_i) |-> !push_i);
    // R5: an unread byte is held steady until read
    a_r5_ready_hold: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (s_q.out_v && !rd_en_i) |=> (s_q.out_v && $stable(s_q.out_data)));
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
    parameter int unsigned FIFO_DEPTH      = 21,
    parameter int unsigned MIN_FRAME_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_clr,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       data_ready,
    output logic       fifo_empty,
    output logic       frame_end,
    output logic       frame_good,
    output logic [7:0] crc_lo,
    output logic [7:0] crc_hi
);
    logic        dvalid, dbit, flag, abort_ev;
    logic        push, commit, rollback;
    logic [7:0]  push_data;
    logic [15:0] crc_val;

    hdlc_bit_stage u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sync_clr),
        .bit_valid_i(bit_valid),
        .bit_in_i   (bit_in),
        .dvalid_o   (dvalid),
        .dbit_o     (dbit),
        .flag_o     (flag),
        .abort_o    (abort_ev)
    );

    hdlc_frame_stage #(.MIN_BYTES(MIN_FRAME_BYTES)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (sync_clr),
        .dvalid_i    (dvalid),
        .dbit_i      (dbit),
        .flag_i      (flag),
        .abort_i     (abort_ev),
        .push_o      (push),
        .push_data_o (push_data),
        .commit_o    (commit),
        .rollback_o  (rollback),
        .frame_end_o (frame_end),
        .frame_good_o(frame_good),
        .crc_o       (crc_val)
    );

    hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (sync_clr),
        .push_i      (push),
        .push_data_i (push_data),
        .commit_i    (commit),
        .rollback_i  (rollback),
        .rd_en_i     (rd_en),
        .rd_data_o   (rd_data),
        .data_ready_o(data_ready),
        .fifo_empty_o(fifo_empty)
    );

    assign crc_lo = crc_val[7:0];
    assign crc_hi = crc_val[15:8];

    // R4: an empty indication never coexists with a ready byte
    a_r4_empty_vs_ready: assert property (@(posedge clk) disable iff (!rst_n || sync_clr)
        data_ready |-> !fifo_empty);
endmodule

// File: tb/test_hdlc_rx_deframer.sv
`timescale 1ns/1ps
module test_hdlc_rx_deframer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_clr = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       data_ready, fifo_empty, frame_end, frame_good;
    logic [7:0] crc_lo, crc_hi;

    int errors = 0;
    int checks = 0;
    int tx_ones = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hdlc_rx_deframer i_hdlc_rx_deframer (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .bit_valid(bit_valid),
        .bit_in(bit_in), .rd_en(rd_en), .rd_data(rd_data), .data_ready(data_ready),
        .fifo_empty(fifo_empty), .frame_end(frame_end), .frame_good(frame_good),
        .crc_lo(crc_lo), .crc_hi(crc_hi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_of(input logic [7:0] q[$]);
        logic [15:0] c;
        logic fb;
        c = 16'hFFFF;
        foreach (q[i]) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ q[i][k];
                c  = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic send_raw(input logic b);
        if ($urandom % 4 == 0) begin
            bit_valid = 1'b0;
            @(negedge clk);
        end
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_dbit(input logic b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int k = 0; k < 8; k++) send_dbit(v[k]);
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        for (int k = 0; k < 6; k++) send_raw(1'b1);
        send_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_frame(input logic [7:0] pay[$], input bit corrupt, output logic [15:0] res);
        logic [7:0]  all[$];
        logic [15:0] fcs;
        all = pay;
        fcs = ~crc_of(pay);
        if (corrupt) fcs[3] = ~fcs[3];
        all.push_back(fcs[7:0]);
        all.push_back(fcs[15:8]);
        res = crc_of(all);
        send_flag();
        foreach (all[i]) send_byte(all[i]);
        send_flag();
    endtask

    task automatic drain(input logic [7:0] exp[$], input string req);
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        while (data_ready === 1'b1) begin
            if (n < exp.size()) chk({req, " byte"}, {24'd0, rd_data}, {24'd0, exp[n]});
            rd_en = 1'b1;
            @(negedge clk);
            n++;
        end
        rd_en = 1'b0;
        chk({req, " byte count"}, n, exp.size());
        chk("R4 fifo_empty after drain", {31'd0, fifo_empty}, 32'd1);
        chk("R5 data_ready cleared after last read", {31'd0, data_ready}, 32'd0);
    endtask

    function automatic logic [7:0] rand_byte();
        case ($urandom % 5)
            0: return 8'hFF;
            1: return 8'h7E;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  pay[$];
        logic [7:0]  none[$];
        logic [15:0] res, last_res;
        logic        last_good;
        logic [31:0] noise;
        void'($urandom(32'd2024));
        none = {};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 fifo_empty", {31'd0, fifo_empty}, 32'd1);
        chk("R12 data_ready", {31'd0, data_ready}, 32'd0);
        chk("R12 frame_end", {31'd0, frame_end}, 32'd0);
        chk("R12 frame_good", {31'd0, frame_good}, 32'd0);
        chk("R12 crc", {16'd0, crc_hi, crc_lo}, 32'd0);

        // R11: noise without six ones in a row before any flag
        noise = 32'hA5C3_3C5A;
        for (int k = 0; k < 32; k++) send_raw(noise[k]);
        repeat (3) @(negedge clk);
        chk("R11 pre-flag noise ignored", {31'd0, fifo_empty}, 32'd1);
        chk("R11 frame_end unchanged", {31'd0, frame_end}, 32'd0);

        // R1/R2 directed frame full of ones and flag-like bytes
        pay = '{8'h7E, 8'hFF, 8'hFF, 8'h00, 8'h7D, 8'h1F};
        send_frame(pay, 1'b0, res);
        repeat (3) @(negedge clk);
        chk("R5 data_ready set on load", {31'd0, data_ready}, 32'd1);
        chk("R6 frame_end set", {31'd0, frame_end}, 32'd1);
        chk("R7 frame_good on clean frame", {31'd0, frame_good}, 32'd1);
        chk("R8 crc registers", {16'd0, crc_hi, crc_lo}, 32'h0000F0B8);
        drain(pay, "R1 R2 directed payload");

        // random frames, some with a corrupted check sequence
        for (int f = 0; f < 24; f++) begin
            bit bad;
            pay = {};
            for (int i = 0; i < 2 + int'($urandom % 11); i++) pay.push_back(rand_byte());
            bad = ($urandom % 3 == 0);
            send_frame(pay, bad, res);
            repeat (3) @(negedge clk);
            chk("R7 frame_good random", {31'd0, frame_good}, {31'd0, res == 16'hF0B8});
            chk("R8 crc random", {16'd0, crc_hi, crc_lo}, {16'd0, res});
            drain(pay, bad ? "R13 payload of failed frame" : "R1 random payload");
            last_res  = res;
            last_good = (res == 16'hF0B8);
        end

        // R9 abort
        send_flag();
        send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
        for (int k = 0; k < 8; k++) send_raw(1'b1);
        tx_ones = 0;
        send_flag();
        repeat (4) @(negedge clk);
        chk("R9 abort leaves nothing", {31'd0, fifo_empty}, 32'd1);
        chk("R9 frame_good kept", {31'd0, frame_good}, {31'd0, last_good});
        chk("R9 crc kept", {16'd0, crc_hi, crc_lo}, {16'd0, last_res});
        chk("R6 frame_end still set", {31'd0, frame_end}, 32'd1);

        // R10 short frame
        send_flag();
        send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
        send_flag();
        repeat (4) @(negedge clk);
        chk("R10 short frame dropped", {31'd0, fifo_empty}, 32'd1);
        chk("R10 crc kept after short", {16'd0, crc_hi, crc_lo}, {16'd0, last_res});

        // R10 misaligned frame
        send_flag();
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        send_dbit(1'b1); send_dbit(1'b0); send_dbit(1'b1);
        send_flag();
        repeat (4) @(negedge clk);
        chk("R10 misaligned frame dropped", {31'd0, fifo_empty}, 32'd1);
        chk("R10 frame_good kept", {31'd0, frame_good}, {31'd0, last_good});
        drain(none, "R10 nothing readable");

        // R3 overflow: 25 payload bytes, only first 21 readable
        pay = {};
        for (int i = 0; i < 25; i++) pay.push_back(8'($urandom));
        send_frame(pay, 1'b0, res);
        repeat (3) @(negedge clk);
        chk("R7 long frame good", {31'd0, frame_good}, 32'd1);
        pay = pay[0:20];
        drain(pay, "R3 overflow clip");

        // R6 clear by sync_clr
        sync_clr = 1'b1;
        @(negedge clk);
        sync_clr = 1'b0;
        @(negedge clk);
        chk("R6 frame_end cleared", {31'd0, frame_end}, 32'd0);
        chk("R12 crc cleared", {16'd0, crc_hi, crc_lo}, 32'd0);

        pay = '{8'hC0, 8'hFF, 8'h3E};
        send_frame(pay, 1'b0, res);
        repeat (3) @(negedge clk);
        chk("R6 frame_end after clear", {31'd0, frame_end}, 32'd1);
        drain(pay, "R1 after clear");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule